// File: doc/BRIEF.md
# Averaging Stochastic Bitstream Rerandomizer

This block combines two single-bit stochastic streams with a clocked Muller C-element. It does not pass the C-element bit through. Instead, it regenerates a fresh output bit every cycle, so that the encoded probability is kept while the long runs of equal bits that a C-element produces are broken up. The regeneration draws an x-bit value from an internal linear feedback shift register and compares it with a count of recent C-element ones. The output is 1 when the random value is the smaller of the two.

Two counting variants are available, chosen by a parameter. The default variant counts C-element ones over consecutive, non-overlapping windows of 2^x cycles. It latches each finished window's count as the comparison level. The alternative variant keeps a 2^x-deep delay line of C-element bits and maintains a running total of the ones inside it. The two variants expose the same ports, so a stage in an inference tree can swap one for the other without any change to its neighbours.

Top module: `bitstream_rerandomizer`

## Requirements
- R1: The internal C-element state becomes 1 when both inputs are 1 and becomes 0 when both are 0. When the two inputs differ, it keeps its previous value.
- R2: In window mode, a cycle counter splits time into back-to-back windows of 2^x cycles. The comparison level is the number of C-element ones in the last finished window. A full window of ones gives a level of 2^x, and the output is then 1 in every cycle.
- R3: At each window end, the level takes the new window's count and the running count restarts at zero. No ones from an earlier window carry into a later one, so after the state turns to 0 the output becomes 0 in every cycle within two windows.
- R4: In every cycle after valid, the registered output is 1 exactly when the low x bits of the generator are less than the level. The output density therefore tracks the density of C-element ones.
- R5: In moving mode, the level is the number of ones among the last 2^x C-element bits. The level changes only when the bit entering the delay line differs from the bit leaving it.
- R6: In both modes, valid_o is low for the first 2^x rising edges after reset is released. It is high from the (2^x+1)-th edge onward and stays high until the next reset.
- R7: While reset is asserted, valid_o and bit_o are 0. Reset clears the C-element state, the counters, the level and the delay line.
- R8: The generator loads seed_i during reset. A seed of zero is replaced by the value 1, so the generator never locks up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_i | input | LFSR_W | Generator seed, loaded while rst is high |
| a_i | input | 1 | First stochastic input stream |
| b_i | input | 1 | Second stochastic input stream |
| bit_o | output | 1 | Rerandomized output bit, registered |
| valid_o | output | 1 | High once the level reflects a full window |

## Verification
A C-element state that is stuck or latched wrongly shows up at the ports as an output that is constant at the wrong value within about two windows after the inputs try to hold or flip it. The directed hold stretches expose this exactly. A counter that mis-sizes the window, fails to clear, or overflows at 2^x ones moves the output density away from the density of C-element ones. A stretch of all ones or all zeros reveals this as an off-by-one in the output after one window. A generator that sticks at zero makes the output stay at 1 for any nonzero level, which the half-density runs detect after a few hundred cycles.

// File: rtl/rerand_pkg.sv
package rerand_pkg;

  typedef enum logic {
    AVG_SINGLE_RUN = 1'b0,
    AVG_MOVING     = 1'b1
  } avg_mode_e;

  // Number of cycles (or delay-line taps) in one averaging window.
  function automatic int unsigned win_len(input int unsigned lg);
    return 32'd1 << lg;
  endfunction

endpackage

// File: rtl/rerand_celem.sv
module rerand_celem (
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  output logic state_q
);

  logic agree_hi;
  logic either_hi;

  assign agree_hi  = a & b;
  assign either_hi = a | b;

  // Holds its value unless both inputs oppose it.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b0;
    end else begin
      state_q <= agree_hi | (state_q & either_hi);
    end
  end

endmodule

// File: rtl/rerand_lfsr.sv
module rerand_lfsr #(
  parameter int unsigned    W    = 16,
  parameter logic [W-1:0]   TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state_q
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] seed_safe;
  logic [W-1:0] step;

  assign seed_safe = (seed == '0) ? ONE : seed;
  assign step      = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= seed_safe;
    end else begin
      state_q <= step;
    end
  end

endmodule

// File: rtl/rerand_window_avg.sv
module rerand_window_avg #(
  parameter int unsigned LG = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sample,
  output logic [LG:0] level,
  output logic      ready
);

  localparam int unsigned         LAST    = (32'd1 << LG) - 32'd1;
  localparam logic [LG-1:0]       CC_LAST = LG'(LAST);

  logic [LG-1:0] cycle_q;
  logic [LG:0]   run_q;
  logic [LG:0]   ave_q;
  logic          ready_q;
  logic          wrap;
  logic [LG:0]   run_next;

  assign wrap     = (cycle_q == CC_LAST);
  assign run_next = run_q + (LG + 1)'(sample);

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_q <= '0;
      run_q   <= '0;
      ave_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      cycle_q <= cycle_q + 1'b1;
      if (wrap) begin
        ave_q   <= run_next;
        run_q   <= '0;
        ready_q <= 1'b1;
      end else begin
        run_q   <= run_next;
      end
    end
  end

  assign level = ave_q;
  assign ready = ready_q;

endmodule

// File: rtl/rerand_moving_avg.sv
module rerand_moving_avg #(
  parameter int unsigned LG = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sample,
  output logic [LG:0] level,
  output logic      ready
);

  localparam int unsigned   DEPTH = 32'd1 << LG;
  localparam logic [LG:0]   FULL  = (LG + 1)'(DEPTH);

  logic [DEPTH-1:0] line_q;
  logic [LG:0]      total_q;
  logic [LG:0]      fill_q;
  logic             oldest;

  assign oldest = line_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      total_q <= '0;
      fill_q  <= '0;
    end else begin
      line_q <= {line_q[DEPTH-2:0], sample};
      if (sample != oldest) begin
        if (sample) total_q <= total_q + 1'b1;
        else        total_q <= total_q - 1'b1;
      end
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
    end
  end

  assign level = total_q;
  assign ready = (fill_q == FULL);

endmodule

// File: rtl/bitstream_rerandomizer.sv
module bitstream_rerandomizer
  import rerand_pkg::*;
#(
  parameter int unsigned        WIN_LOG2  = 4,
  parameter int unsigned        LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'hB400,
  parameter avg_mode_e          MODE      = AVG_SINGLE_RUN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              a_i,
  input  logic              b_i,
  output logic              bit_o,
  output logic              valid_o
);

  logic                 cel_q;
  logic [WIN_LOG2:0]    level_w;
  logic                 ready_w;
  logic [LFSR_W-1:0]    rng_q;
  logic [WIN_LOG2-1:0]  draw;
  logic                 hit;

  rerand_celem u_celem (
    .clk     (clk),
    .rst     (rst),
    .a       (a_i),
    .b       (b_i),
    .state_q (cel_q)
  );

  rerand_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_TAPS)
  ) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .seed    (seed_i),
    .state_q (rng_q)
  );

  generate
    if (MODE == AVG_MOVING) begin : g_moving
      rerand_moving_avg #(.LG(WIN_LOG2)) u_avg (
        .clk    (clk),
        .rst    (rst),
        .sample (cel_q),
        .level  (level_w),
        .ready  (ready_w)
      );
    end else begin : g_window
      rerand_window_avg #(.LG(WIN_LOG2)) u_avg (
        .clk    (clk),
        .rst    (rst),
        .sample (cel_q),
        .level  (level_w),
        .ready  (ready_w)
      );
    end
  endgenerate

  assign draw = rng_q[WIN_LOG2-1:0];
  assign hit  = ({1'b0, draw} < level_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      bit_o   <= hit;
      valid_o <= ready_w;
    end
  end

endmodule

// File: rtl/rerand_checker.sv
module rerand_checker #(
  parameter int unsigned WIN_LOG2 = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              a_i,
  input logic              b_i,
  input logic              bit_o,
  input logic              valid_o,
  input logic              cel_q,
  input logic [WIN_LOG2:0] level
);

  localparam logic [WIN_LOG2:0] FULL = (WIN_LOG2 + 1)'(32'd1 << WIN_LOG2);

  // R1
  celem_set_chk: assert property (@(posedge clk) disable iff (rst)
    (a_i && b_i) |=> cel_q);

  // R1
  celem_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_i && !b_i) |=> !cel_q);

  // R2
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    level <= FULL);

  // R4
  zero_level_chk: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> !bit_o);

  // R4
  full_level_chk: assert property (@(posedge clk) disable iff (rst)
    (level == FULL) |=> bit_o);

  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o);

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!valid_o && !bit_o));

endmodule

bind bitstream_rerandomizer rerand_checker #(.WIN_LOG2(WIN_LOG2)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a_i     (a_i),
  .b_i     (b_i),
  .bit_o   (bit_o),
  .valid_o (valid_o),
  .cel_q   (cel_q),
  .level   (level_w)
);

// File: tb/test_bitstream_rerandomizer.sv
module test_bitstream_rerandomizer;
  import rerand_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LG         = 4;
  localparam int W          = 1 << LG;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] seed = 16'hACE1;
  logic        a = 1'b0;
  logic        b = 1'b0;
  logic        bit_s, val_s, bit_m, val_m;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic cs_model = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitstream_rerandomizer #(.WIN_LOG2(LG), .MODE(AVG_SINGLE_RUN)) i_bitstream_rerandomizer (
    .clk(clk), .rst(rst), .seed_i(seed), .a_i(a), .b_i(b),
    .bit_o(bit_s), .valid_o(val_s)
  );

  bitstream_rerandomizer #(.WIN_LOG2(LG), .MODE(AVG_MOVING)) i_bitstream_rerandomizer_ma (
    .clk(clk), .rst(rst), .seed_i(seed), .a_i(a), .b_i(b),
    .bit_o(bit_m), .valid_o(val_m)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic cel_next(input logic s, input logic x, input logic y);
    return (x & y) | (s & (x | y));
  endfunction

  // Drive one cycle of inputs at the falling edge and track the C-element.
  task automatic drive(input logic x, input logic y);
    @(negedge clk);
    a = x; b = y;
    cs_model = cel_next(cs_model, x, y);
  endtask

  task automatic do_reset(input logic [15:0] s);
    @(negedge clk);
    rst = 1'b1; seed = s; a = 1'b0; b = 1'b0; cs_model = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(val_s == 1'b0 && bit_s == 1'b0, "R7 window", {val_s, bit_s}, 0);
    chk(val_m == 1'b0 && bit_m == 1'b0, "R7 moving", {val_m, bit_m}, 0);
    rst = 1'b0;
  endtask

  // Hold inputs for 4 windows; check the second half against a constant output.
  task automatic hold(input logic x, input logic y, input logic exp, input string req);
    int bad_s = 0, bad_m = 0;
    for (int i = 0; i < 4*W; i++) begin
      @(negedge clk);
      if (i >= 2*W + 2) begin
        if (bit_s !== exp) bad_s++;
        if (bit_m !== exp) bad_m++;
      end
      a = x; b = y;
      cs_model = cel_next(cs_model, x, y);
    end
    chk(bad_s == 0, {req, " window"}, bad_s, 0);
    chk(bad_m == 0, {req, " moving"}, bad_m, 0);
  endtask

  // Measure output density (per mille) against C-element density.
  task automatic density(input int pa, input int pb, input bit alt, input int n, input string req);
    int ones_s = 0, ones_m = 0, ones_c = 0;
    for (int i = 0; i < n + 3*W; i++) begin
      logic x, y;
      @(negedge clk);
      if (i >= 3*W) begin
        ones_s += int'(bit_s);
        ones_m += int'(bit_m);
        ones_c += int'(cs_model);
      end
      if (alt) begin x = logic'(i % 2); y = x; end
      else begin
        x = logic'(($urandom % 100) < pa);
        y = logic'(($urandom % 100) < pb);
      end
      a = x; b = y;
      cs_model = cel_next(cs_model, x, y);
    end
    begin
      int ps = ones_s * 1000 / n;
      int pm = ones_m * 1000 / n;
      int pc = ones_c * 1000 / n;
      chk(ps > pc - 60 && ps < pc + 60, {req, " window"}, ps, pc);
      chk(pm > pc - 60 && pm < pc + 60, {req, " moving"}, pm, pc);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R7, R6: reset state and valid timing
    do_reset(16'hACE1);
    for (int k = 1; k <= W + 1; k++) begin
      @(negedge clk);
      if (k == W) begin
        chk(val_s == 1'b0, "R6 window low at W", val_s, 0);
        chk(val_m == 1'b0, "R6 moving low at W", val_m, 0);
      end
      if (k == W + 1) begin
        chk(val_s == 1'b1, "R6 window high at W+1", val_s, 1);
        chk(val_m == 1'b1, "R6 moving high at W+1", val_m, 1);
      end
    end
    // R1: differing inputs hold a 0 state
    hold(1'b1, 1'b0, 1'b0, "R1 hold0");
    drive(1'b1, 1'b1);
    // R1, R2, R5: differing inputs hold a 1 state, full window of ones
    hold(1'b0, 1'b1, 1'b1, "R1 R2 R5 hold1");
    // R3, R5: ones do not linger after state clears
    hold(1'b0, 1'b0, 1'b0, "R3 R5 clear");
    hold(1'b1, 1'b1, 1'b1, "R2 R5 ones");
    // R4: half-density and random patterns
    density(0, 0, 1'b1, 4096, "R4 alternating");
    density(70, 70, 1'b0, 8000, "R4 random 70/70");
    density(30, 60, 1'b0, 8000, "R4 random 30/60");
    // R7: reset in the middle of activity, then zero seed
    do_reset(16'h0000);
    for (int k = 0; k < W + 1; k++) @(negedge clk);
    chk(val_s && val_m, "R6 after mid-run reset", {val_s, val_m}, 3);
    // R8: zero seed must still give a live generator
    density(0, 0, 1'b1, 4096, "R8 zero seed");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule